// File: doc/BRIEF.md
# Asynchronous Byte-Lane Static RAM Model

This block is a synthesizable stand-in for an asynchronous static RAM with a 16-bit data path split into two byte lanes. The external strobes (chip select, write strobe, output enable and one enable per byte lane, all active low) are sampled by a fast internal clock. The sampled strobes are decoded into standby, read, write and output-disabled modes. For each lane the model then decides whether to drive read data, take write data, or leave the lane floating.

The data bus is split into a write-data input, a read-data output and a per-lane drive enable, so a surrounding bench or a pad wrapper can build the tri-state bus. A write is open only while chip select, the write strobe and at least one lane enable are all active. The value stored is the one present just before the strobe that closes the window. The memory depth is a parameter, so the model can be built small while keeping the full 19-bit address port.

Top module: `sram_lane_model`

## Requirements
- R1: When sampled chip select is high, or both lane enables are high, `standby` is 1 and `laneDrive` is 2'b00.
- R2: With chip select low, output enable low and write strobe high, one clock after sampling `laneDrive[0]` is 1 exactly when the low-lane enable is low and `laneDrive[1]` is 1 exactly when the high-lane enable is low. On each driven lane, `dataOut` carries that lane's byte of the addressed word (bits 7:0 low lane, bits 15:8 high lane).
- R3: A write stores `dataIn[7:0]` only if the low-lane enable was low, and `dataIn[15:8]` only if the high-lane enable was low. The byte of a lane that was not enabled keeps its old value.
- R4: `laneDrive` is 2'b00 in the cycle after output enable was sampled high. It is also 2'b00 in the cycle after chip select and write strobe were both sampled low, whatever the level of output enable.
- R5: The write window is open only while chip select is low, the write strobe is low and at least one lane enable is low. Raising the write strobe, raising chip select, or raising both lane enables each closes the window and commits the write. Chip select and write strobe low with both lanes disabled stores nothing.
- R6: The word committed is the data, address and lane set sampled on the last clock before the window closed. Earlier data in the same window is overwritten, and each window commits exactly once.
- R7: During a read, a change of address shows the new word on `dataOut` one clock later, without any strobe toggling.
- R8: Only the low `DEPTH_LOG2` address bits select a word. Addresses that differ only above them name the same word.
- R9: After reset, `standby` is 1 and `laneDrive` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low reset of the sampling and control state |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | 16 | Write data as seen on the bus |
| chipSelN | input | 1 | Chip select, active low |
| writeStrN | input | 1 | Write strobe, active low |
| outEnN | input | 1 | Output enable, active low |
| loLaneN | input | 1 | Low byte lane enable, active low |
| hiLaneN | input | 1 | High byte lane enable, active low |
| dataOut | output | 16 | Read data for the lanes being driven |
| laneDrive | output | 2 | Per-lane output drive enable (bit 0 low lane) |
| standby | output | 1 | High while the device is deselected |

## Verification
The bench keeps ADDR_W at 19 but builds the model with DEPTH_LOG2 = 4, so the array has sixteen words. A write at address 0x12 therefore lands on word 2, which makes the aliasing of the unused upper address bits observable. The small array also lets the bench keep a full reference copy and confirm that untouched bytes survive partial-lane writes. All three ways of ending a write, and a data change inside an open window, are each exercised at this size.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Strobes passed from control to datapath each clock
  typedef struct packed {
    logic             capture;  // write window open this cycle
    logic             commit;   // window closed this cycle, store held word
    logic [LANES-1:0] wrLanes;  // lanes enabled in the sampled strobes
    logic [LANES-1:0] rdLanes;  // lanes to drive onto the bus
  } laneStrb_t;

endpackage

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             writeStrN,
  input  logic             outEnN,
  input  logic [LANES-1:0] laneEnN,
  output laneStrb_t        strb,
  output logic             standby
);

  logic             ceQ;
  logic             weQ;
  logic             oeQ;
  logic [LANES-1:0] laneQ;
  logic             wasOpenQ;

  logic anyLane;
  logic deselect;
  logic winOpen;
  logic readAct;

  // Sample the asynchronous strobes; inactive level on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ      <= 1'b1;
      weQ      <= 1'b1;
      oeQ      <= 1'b1;
      laneQ    <= '1;
      wasOpenQ <= 1'b0;
    end else begin
      ceQ      <= chipSelN;
      weQ      <= writeStrN;
      oeQ      <= outEnN;
      laneQ    <= laneEnN;
      wasOpenQ <= winOpen;
    end
  end

  always_comb begin
    anyLane  = |(~laneQ);
    deselect = ceQ | ~anyLane;
    winOpen  = ~ceQ & ~weQ & anyLane;
    readAct  = ~deselect & weQ & ~oeQ;

    strb.capture = winOpen;
    strb.commit  = wasOpenQ & ~winOpen;
    strb.wrLanes = ~laneQ;
    strb.rdLanes = readAct ? ~laneQ : '0;
  end

  assign standby = deselect;

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit); // R6

endmodule

// File: rtl/sram_lane_data.sv
module sram_lane_data
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  laneStrb_t         strb,
  output logic [DATA_W-1:0] dataOut,
  output logic [LANES-1:0]  laneDrive
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     dataQ;
  logic [DEPTH_LOG2-1:0] holdAddr;
  logic [DATA_W-1:0]     holdData;
  logic [LANES-1:0]      holdMask;
  logic [DEPTH_LOG2-1:0] rdIdx;

  // Sample address and data every clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= addrIn;
      dataQ <= dataIn;
    end
  end

  // Hold the latest word seen while the window is open
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
      holdMask <= '0;
    end else if (strb.capture) begin
      holdAddr <= addrQ[DEPTH_LOG2-1:0];
      holdData <= dataQ;
      holdMask <= strb.wrLanes;
    end
  end

  assign rdIdx = addrQ[DEPTH_LOG2-1:0];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.commit && holdMask[g])
        bank[holdAddr] <= holdData[g*LANE_W +: LANE_W];
    end

    assign dataOut[g*LANE_W +: LANE_W] = bank[rdIdx];
  end

  assign laneDrive = strb.rdLanes;

  AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> holdMask != '0); // R5

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              chipSelN,
  input  logic              writeStrN,
  input  logic              outEnN,
  input  logic              loLaneN,
  input  logic              hiLaneN,
  output logic [DATA_W-1:0] dataOut,
  output logic [LANES-1:0]  laneDrive,
  output logic              standby
);

  laneStrb_t strb;

  sram_lane_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipSelN  (chipSelN),
    .writeStrN (writeStrN),
    .outEnN    (outEnN),
    .laneEnN   ({hiLaneN, loLaneN}),
    .strb      (strb),
    .standby   (standby)
  );

  sram_lane_data #(
    .ADDR_W     (ADDR_W),
    .DEPTH_LOG2 (DEPTH_LOG2)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .strb      (strb),
    .dataOut   (dataOut),
    .laneDrive (laneDrive)
  );

  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> laneDrive == '0); // R1

  AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(chipSelN) && !$past(writeStrN)) |-> laneDrive == '0); // R4

  AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    $past(outEnN) |-> laneDrive == '0); // R4

  AST_READ_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (laneDrive != '0) |-> (!$past(chipSelN) && $past(writeStrN) && !$past(outEnN))); // R2

endmodule

// File: tb/sram_lane_model_test.sv
module sram_lane_model_test;

  localparam int ADDR_W = 19;
  localparam int DLOG   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [15:0]       dataIn = '0;
  logic              chipSelN = 1'b1;
  logic              writeStrN = 1'b1;
  logic              outEnN = 1'b1;
  logic              loLaneN = 1'b1;
  logic              hiLaneN = 1'b1;
  logic [15:0]       dataOut;
  logic [1:0]        laneDrive;
  logic              standby;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] refMem [16];

  always #2 clk = ~clk;

  sram_lane_model #(.ADDR_W(ADDR_W), .DEPTH_LOG2(DLOG)) uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .chipSelN(chipSelN), .writeStrN(writeStrN), .outEnN(outEnN),
    .loLaneN(loLaneN), .hiLaneN(hiLaneN),
    .dataOut(dataOut), .laneDrive(laneDrive), .standby(standby)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic goIdle();
    @(negedge clk);
    chipSelN = 1'b1; writeStrN = 1'b1; outEnN = 1'b1; loLaneN = 1'b1; hiLaneN = 1'b1;
  endtask

  // term: 0 write strobe, 1 chip select, 2 both lane enables
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [15:0] dA,
                         input logic [15:0] dB, input logic [1:0] lanes,
                         input int term, input logic oeLvl);
    @(negedge clk);
    addrIn = a; dataIn = dA; chipSelN = 1'b0; writeStrN = 1'b0;
    outEnN = oeLvl; loLaneN = ~lanes[0]; hiLaneN = ~lanes[1];
    @(negedge clk);
    chk(laneDrive == 2'b00, "R4 float during write", {14'd0, laneDrive}, 16'd0);
    dataIn = dB;
    @(negedge clk);
    if (term == 0) writeStrN = 1'b1;
    else if (term == 1) chipSelN = 1'b1;
    else begin loLaneN = 1'b1; hiLaneN = 1'b1; end
    dataIn = 16'hDEAD;
    @(negedge clk);
    @(negedge clk);
    if (lanes[0]) refMem[a[DLOG-1:0]][7:0]  = dB[7:0];
    if (lanes[1]) refMem[a[DLOG-1:0]][15:8] = dB[15:8];
    goIdle();
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [1:0] lanes, input string req);
    logic [15:0] m;
    logic [15:0] e;
    @(negedge clk);
    addrIn = a; chipSelN = 1'b0; writeStrN = 1'b1; outEnN = 1'b0;
    loLaneN = ~lanes[0]; hiLaneN = ~lanes[1];
    @(negedge clk);
    m = {{8{lanes[1]}}, {8{lanes[0]}}};
    e = refMem[a[DLOG-1:0]];
    chk(laneDrive == lanes, {req, " R2 lane drive"}, {14'd0, laneDrive}, {14'd0, lanes});
    chk((dataOut & m) == (e & m), {req, " data"}, dataOut & m, e & m);
    goIdle();
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(standby == 1'b1, "R9 standby after reset", {15'd0, standby}, 16'd1);
    chk(laneDrive == 2'b00, "R9 no drive after reset", {14'd0, laneDrive}, 16'd0);
  endtask

  task automatic testFullWrite();
    doWrite(19'd3, 16'hA1B2, 16'hA1B2, 2'b11, 0, 1'b1);
    doRead(19'd3, 2'b11, "R3 R5 full word, strobe end");
  endtask

  task automatic testLowLaneChipEnd();
    doWrite(19'd3, 16'h5566, 16'h5566, 2'b01, 1, 1'b1);
    doRead(19'd3, 2'b11, "R3 R5 low lane only, chip select end");
  endtask

  task automatic testHighLaneLaneEnd();
    doWrite(19'd5, 16'h0000, 16'h0000, 2'b11, 0, 1'b1);
    doWrite(19'd5, 16'hC3C3, 16'hC3C3, 2'b10, 2, 1'b0);
    doRead(19'd5, 2'b11, "R3 R5 high lane only, lane enable end, R4 oe low");
  endtask

  task automatic testLastData();
    doWrite(19'd7, 16'h1111, 16'h2222, 2'b11, 0, 1'b1);
    doRead(19'd7, 2'b11, "R6 last sampled data wins");
  endtask

  task automatic testSingleLaneRead();
    doRead(19'd3, 2'b01, "R2 low lane read, high floats");
    doRead(19'd3, 2'b10, "R2 high lane read, low floats");
  endtask

  task automatic testOutputDisabled();
    @(negedge clk);
    addrIn = 19'd3; chipSelN = 1'b0; writeStrN = 1'b1; outEnN = 1'b1;
    loLaneN = 1'b0; hiLaneN = 1'b0;
    @(negedge clk);
    chk(laneDrive == 2'b00, "R4 output enable high floats bus", {14'd0, laneDrive}, 16'd0);
    chk(standby == 1'b0, "R1 selected is not standby", {15'd0, standby}, 16'd0);
    goIdle();
  endtask

  task automatic testLaneDeselect();
    @(negedge clk);
    addrIn = 19'd7; dataIn = 16'hBEEF; chipSelN = 1'b0; writeStrN = 1'b0;
    outEnN = 1'b0; loLaneN = 1'b1; hiLaneN = 1'b1;
    @(negedge clk);
    chk(standby == 1'b1, "R1 both lanes off is standby", {15'd0, standby}, 16'd1);
    chk(laneDrive == 2'b00, "R1 standby floats bus", {14'd0, laneDrive}, 16'd0);
    @(negedge clk);
    writeStrN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    goIdle();
    doRead(19'd7, 2'b11, "R5 no lane enabled stores nothing");
    @(negedge clk);
    chipSelN = 1'b1; loLaneN = 1'b0; hiLaneN = 1'b0; outEnN = 1'b0;
    @(negedge clk);
    chk(standby == 1'b1, "R1 chip select high is standby", {15'd0, standby}, 16'd1);
    chk(laneDrive == 2'b00, "R1 chip select high floats", {14'd0, laneDrive}, 16'd0);
    goIdle();
  endtask

  task automatic testAddrFollow();
    @(negedge clk);
    addrIn = 19'd3; chipSelN = 1'b0; writeStrN = 1'b1; outEnN = 1'b0;
    loLaneN = 1'b0; hiLaneN = 1'b0;
    @(negedge clk);
    chk(dataOut == refMem[3], "R7 first address", dataOut, refMem[3]);
    addrIn = 19'd7;
    @(negedge clk);
    chk(dataOut == refMem[7], "R7 address change follows", dataOut, refMem[7]);
    goIdle();
  endtask

  task automatic testAlias();
    doWrite(19'h12, 16'h7E57, 16'h7E57, 2'b11, 0, 1'b1);
    doRead(19'd2, 2'b11, "R8 upper address bits ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFullWrite();
    testLowLaneChipEnd();
    testHighLaneLaneEnd();
    testLastData();
    testSingleLaneRead();
    testOutputDisabled();
    testLaneDeselect();
    testAddrFollow();
    testAlias();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule